// File: doc/BRIEF.md
# Serial Control Register Bank with Status Readback

This block is a two-wire serial slave that keeps a bank of byte-wide control registers for a tuner front end and answers reads with a single live status byte. Both bus lines are sampled through synchronizers on the system clock. The block pulls the data line low through an open-drain enable and never drives it high. Two strap pins set the low bits of the 7-bit device address. The rest of the address is fixed.

A write transaction sends the device address, then a register pointer, then any number of data bytes. Each data byte lands at the pointer, and the pointer then advances by one. A read transaction returns a status byte built from a lock flag and a 3-bit sub-band code, which are captured when the address is matched. The full register contents are presented in parallel for the analog and PLL control logic to use.

Top module: `i2c_ctl_regbank`

## Requirements
- R1: The device answers only to the 7-bit address formed from binary 11000 followed by strap_i[1] and strap_i[0]. The eighth address bit selects the direction, with 0 for write and 1 for read. A matching address is acknowledged by pulling SDA low during the ninth clock.
- R2: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. A stop releases SDA. A stop in the middle of a data byte stores nothing.
- R3: Bytes travel MSB first. Received bits are taken on the rising edge of SCL, and SDA is changed by the slave only while SCL is low.
- R4: In a write, the byte after the address is the register pointer, and each following byte is stored at the pointer, which then increments. Each register appears on regs_o[8*i+7:8*i].
- R5: Data bytes whose pointer is above 0x0B (the last of the 12 registers) are acknowledged but leave every register unchanged, and the pointer does not wrap back to 0x00.
- R6: A non-matching address byte is not acknowledged. SDA stays released and no register changes until the next start.
- R7: The read byte is {lock, 0, subband[2:0], 000}, with lock 1 meaning locked.
- R8: The status inputs are captured at the address byte of a read. Later input changes do not alter the bytes returned in that transaction, including repeated bytes after a master acknowledge.
- R9: When the master does not acknowledge a read byte, the slave releases SDA and transmits nothing further until a new start.
- R10: After reset all registers read 0 and SDA is released.
- R11: Within one write transaction, every byte after the pointer is data. A second pointer byte cannot be interleaved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| strap_i | input | 2 | Low two bits of the device address |
| lock_i | input | 1 | PLL lock flag for the status byte |
| subband_i | input | 3 | Sub-band code for the status byte |
| regs_o | output | NREG*8 | All registers, register i at bits 8*i+7:8*i |

## Verification
The assertions check the following properties on every cycle:
- SDA is released after a stop, while idle, and while ignoring the bus.
- The data line moves only while the synchronized clock is low, apart from the release that follows a start or stop.
- No store ever targets a register index outside the bank.
- The register outputs change only on an issued store.

The bench's scenarios show the rest:
- Address matching against different strap values.
- Pointer auto-increment and the discard of bytes past 0x0B.
- The status byte value and its capture at the address byte.
- Silence after a master NACK, and a write aborted by a stop.

These need whole transactions and a model of the expected register contents.

// File: rtl/i2c_rb_pkg.sv
package i2c_rb_pkg;
   localparam int BYTE_W = 8;
   localparam logic [4:0] DEV_PREFIX = 5'b11000;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX,
      ST_ACK_WAIT,
      ST_RX_ACK,
      ST_TX,
      ST_TX_ACK,
      ST_TX_WAIT,
      ST_IGNORE
   } rb_state_e;

   typedef enum logic [1:0] {
      K_ADDR,
      K_SUB,
      K_DATA
   } rb_kind_e;

   // status byte layout: lock, zero, sub-band code, three zeros
   function automatic logic [BYTE_W-1:0] pack_status(input logic lock, input logic [2:0] sb);
      return {lock, 1'b0, sb, 3'b000};
   endfunction
endpackage

// File: rtl/i2c_rb_sync.sv
module i2c_rb_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_p,
   output logic stop_p
);
   localparam int TOP = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("i2c_rb_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] scl_q, sda_q;
   logic              scl_d, sda_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= '1;
         sda_q <= '1;
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_q <= {scl_q[TOP-1:0], scl_i};
         sda_q <= {sda_q[TOP-1:0], sda_i};
         scl_d <= scl_q[TOP];
         sda_d <= sda_q[TOP];
      end
   end

   assign scl_s    = scl_q[TOP];
   assign sda_s    = sda_q[TOP];
   assign scl_rise = scl_q[TOP] & ~scl_d;
   assign scl_fall = ~scl_q[TOP] & scl_d;
   assign start_p  = scl_q[TOP] & scl_d & sda_d & ~sda_q[TOP];
   assign stop_p   = scl_q[TOP] & scl_d & ~sda_d & sda_q[TOP];
endmodule

// File: rtl/i2c_rb_engine.sv
module i2c_rb_engine
   import i2c_rb_pkg::*;
#(
   parameter int NREG = 12,
   parameter int RAW  = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            scl_rise,
   input  logic            scl_fall,
   input  logic            sda_s,
   input  logic            start_p,
   input  logic            stop_p,
   input  logic [1:0]      strap_i,
   input  logic            lock_i,
   input  logic [2:0]      subband_i,
   output logic            sda_oe,
   output logic            we,
   output logic [RAW-1:0]  waddr,
   output logic [BYTE_W-1:0] wdata,
   output rb_state_e       st_o
);
   localparam logic [BYTE_W-1:0] LAST_IDX = BYTE_W'(NREG - 1);

   if (NREG < 1 || NREG > 256) begin : g_bad_nreg
      $error("i2c_rb_engine: NREG out of range");
   end

   rb_state_e         st_q;
   rb_kind_e          kind_q;
   logic [2:0]        cnt_q;
   logic [BYTE_W-1:0] sh_q, ptr_q, stat_q, txb_q;
   logic              rw_q;
   logic [BYTE_W-1:0] rx_byte;

   assign rx_byte = {sh_q[BYTE_W-2:0], sda_s};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         kind_q <= K_ADDR;
         cnt_q  <= '0;
         sh_q   <= '0;
         ptr_q  <= '0;
         stat_q <= '0;
         txb_q  <= '0;
         rw_q   <= 1'b0;
         sda_oe <= 1'b0;
         we     <= 1'b0;
         waddr  <= '0;
         wdata  <= '0;
      end else begin
         we <= 1'b0;
         if (start_p) begin
            st_q   <= ST_RX;
            kind_q <= K_ADDR;
            cnt_q  <= '0;
            sda_oe <= 1'b0;
         end else if (stop_p) begin
            st_q   <= ST_IDLE;
            sda_oe <= 1'b0;
         end else begin
            unique case (st_q)
               ST_RX: if (scl_rise) begin
                  sh_q  <= rx_byte;
                  cnt_q <= cnt_q + 3'd1;
                  if (cnt_q == 3'd7) begin
                     unique case (kind_q)
                        K_ADDR: begin
                           if (rx_byte[7:1] == {DEV_PREFIX, strap_i}) begin
                              rw_q   <= rx_byte[0];
                              kind_q <= rx_byte[0] ? K_ADDR : K_SUB;
                              stat_q <= pack_status(lock_i, subband_i);
                              st_q   <= ST_ACK_WAIT;
                           end else begin
                              st_q <= ST_IGNORE;
                           end
                        end
                        K_SUB: begin
                           ptr_q  <= rx_byte;
                           kind_q <= K_DATA;
                           st_q   <= ST_ACK_WAIT;
                        end
                        default: begin
                           if (ptr_q <= LAST_IDX) begin
                              we    <= 1'b1;
                              waddr <= ptr_q[RAW-1:0];
                              wdata <= rx_byte;
                           end
                           if (ptr_q != '1) ptr_q <= ptr_q + 1'b1;
                           st_q <= ST_ACK_WAIT;
                        end
                     endcase
                  end
               end
               ST_ACK_WAIT: if (scl_fall) begin
                  sda_oe <= 1'b1;
                  st_q   <= ST_RX_ACK;
               end
               ST_RX_ACK: if (scl_fall) begin
                  cnt_q <= '0;
                  if (kind_q == K_ADDR && rw_q) begin
                     txb_q  <= stat_q;
                     sda_oe <= ~stat_q[BYTE_W-1];
                     st_q   <= ST_TX;
                  end else begin
                     sda_oe <= 1'b0;
                     st_q   <= ST_RX;
                  end
               end
               ST_TX: if (scl_fall) begin
                  if (cnt_q == 3'd7) begin
                     sda_oe <= 1'b0;
                     st_q   <= ST_TX_ACK;
                  end else begin
                     cnt_q  <= cnt_q + 3'd1;
                     txb_q  <= {txb_q[BYTE_W-2:0], 1'b0};
                     sda_oe <= ~txb_q[BYTE_W-2];
                  end
               end
               ST_TX_ACK: if (scl_rise) begin
                  st_q <= sda_s ? ST_IGNORE : ST_TX_WAIT;
               end
               ST_TX_WAIT: if (scl_fall) begin
                  cnt_q  <= '0;
                  txb_q  <= stat_q;
                  sda_oe <= ~stat_q[BYTE_W-1];
                  st_q   <= ST_TX;
               end
               default: ;
            endcase
         end
      end
   end

   assign st_o = st_q;
endmodule

// File: rtl/i2c_rb_regfile.sv
module i2c_rb_regfile #(
   parameter int NREG = 12,
   parameter int DW   = 8,
   parameter int RAW  = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we,
   input  logic [RAW-1:0]  waddr,
   input  logic [DW-1:0]   wdata,
   output logic [NREG*DW-1:0] regs_o
);
   if ((1 << RAW) < NREG) begin : g_bad_raw
      $error("i2c_rb_regfile: RAW too narrow for NREG");
   end

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      logic [DW-1:0] r_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                              r_q <= '0;
         else if (we && waddr == RAW'(i))         r_q <= wdata;
      end
      assign regs_o[i*DW +: DW] = r_q;
   end
endmodule

// File: rtl/i2c_ctl_regbank.sv
module i2c_ctl_regbank
   import i2c_rb_pkg::*;
#(
   parameter int NREG        = 12,
   parameter int SYNC_STAGES = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   scl_i,
   input  logic                   sda_i,
   output logic                   sda_oe,
   input  logic [1:0]             strap_i,
   input  logic                   lock_i,
   input  logic [2:0]             subband_i,
   output logic [NREG*BYTE_W-1:0] regs_o
);
   localparam int RAW = (NREG > 1) ? $clog2(NREG) : 1;

   logic              scl_s, sda_s, scl_rise, scl_fall, start_p, stop_p;
   logic              reg_we;
   logic [RAW-1:0]    reg_waddr;
   logic [BYTE_W-1:0] reg_wdata;
   rb_state_e         eng_st;

   i2c_rb_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_p(start_p), .stop_p(stop_p)
   );

   i2c_rb_engine #(.NREG(NREG), .RAW(RAW)) u_eng (
      .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .sda_s(sda_s), .start_p(start_p), .stop_p(stop_p), .strap_i(strap_i),
      .lock_i(lock_i), .subband_i(subband_i), .sda_oe(sda_oe),
      .we(reg_we), .waddr(reg_waddr), .wdata(reg_wdata), .st_o(eng_st)
   );

   i2c_rb_regfile #(.NREG(NREG), .DW(BYTE_W), .RAW(RAW)) u_rf (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .waddr(reg_waddr),
      .wdata(reg_wdata), .regs_o(regs_o)
   );
endmodule

// File: rtl/i2c_rb_checker.sv
module i2c_rb_checker
   import i2c_rb_pkg::*;
#(
   parameter int NREG = 12,
   parameter int RAW  = 4
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   sda_oe,
   input logic                   scl_s,
   input logic                   start_p,
   input logic                   stop_p,
   input logic                   we,
   input logic [RAW-1:0]         waddr,
   input logic [NREG*BYTE_W-1:0] regs_o,
   input rb_state_e              st
);
   assert_stop_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
      stop_p |=> !sda_oe);

   assert_sda_low_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> (!scl_s || $past(stop_p) || $past(start_p)));

   assert_store_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(regs_o));

   assert_store_in_bank_R5: assert property (@(posedge clk) disable iff (!rst_n)
      we |-> (int'(waddr) < NREG));

   assert_ignore_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IGNORE) |-> !sda_oe);

   assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE) |-> !sda_oe);
endmodule

bind i2c_ctl_regbank i2c_rb_checker #(.NREG(NREG), .RAW(RAW)) u_chk (
   .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .scl_s(scl_s),
   .start_p(start_p), .stop_p(stop_p), .we(reg_we), .waddr(reg_waddr),
   .regs_o(regs_o), .st(eng_st)
);

// File: tb/i2c_ctl_regbank_bench.sv
module i2c_ctl_regbank_bench;
   localparam int NREG = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl = 1'b1;
   logic sda_m = 1'b1;
   logic [1:0] strap = 2'b10;
   logic lock = 1'b0;
   logic [2:0] sb = 3'd0;
   logic sda_oe;
   logic [NREG*8-1:0] regs_o;
   logic sda_line;

   assign sda_line = sda_m & ~sda_oe;

   i2c_ctl_regbank u_i2c_ctl_regbank (
      .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
      .strap_i(strap), .lock_i(lock), .subband_i(sb), .regs_o(regs_o)
   );

   always #5 clk = ~clk;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;
   bit cmp_en = 0;
   logic [7:0] exp_regs [NREG];
   bit pend_v = 0;
   int pend_i = 0;
   logic [7:0] pend_d = 8'h00;
   logic [7:0] wbuf [8];

   // reference register image compared against the outputs on every clock (R4, R5)
   always @(negedge clk) begin
      if (cmp_en && !done) begin
         n_chk++;
         for (int i = 0; i < NREG; i++) begin
            if (regs_o[i*8 +: 8] !== exp_regs[i]) begin
               n_bad++;
               $display("FAIL R4 reg%0d act=%h exp=%h", i, regs_o[i*8 +: 8], exp_regs[i]);
            end
         end
      end
   end

   task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; scl = 1'b1; tick(8);
      sda_m = 1'b0; tick(8);
      scl = 1'b0; tick(4);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; tick(4);
      scl = 1'b1; tick(8);
      sda_m = 1'b1; tick(8);
   endtask

   // one SCL period; a pending store enters the model four edges after SCL rises
   task automatic clk_bit(input logic b, output logic seen);
      sda_m = b; tick(4);
      scl = 1'b1;
      repeat (4) @(posedge clk);
      if (pend_v) begin
         exp_regs[pend_i] = pend_d;
         pend_v = 0;
      end
      @(negedge clk);
      seen = sda_line;
      tick(3);
      scl = 1'b0; tick(4);
   endtask

   task automatic send_byte(input logic [7:0] b, input int widx, output logic ack);
      logic s;
      for (int i = 7; i >= 0; i--) begin
         if (i == 0 && widx >= 0) begin
            pend_v = 1; pend_i = widx; pend_d = b;
         end
         clk_bit(b[i], s);
      end
      clk_bit(1'b1, s);
      ack = ~s;
   endtask

   task automatic recv_byte(input logic mack, output logic [7:0] v);
      logic s;
      for (int i = 7; i >= 0; i--) begin
         clk_bit(1'b1, s);
         v[i] = s;
      end
      clk_bit(~mack, s);
   endtask

   task automatic wr_txn(input logic [7:0] adr, input logic [7:0] sub, input int n, input string req);
      logic a;
      int ptr;
      ptr = int'(sub);
      bus_start();
      send_byte(adr, -1, a);       check8({req, " addr ack"}, {7'd0, a}, 8'd1);
      send_byte(sub, -1, a);       check8({req, " sub ack"}, {7'd0, a}, 8'd1);
      for (int k = 0; k < n; k++) begin
         send_byte(wbuf[k], (ptr < NREG) ? ptr : -1, a);
         check8({req, " data ack"}, {7'd0, a}, 8'd1);
         ptr++;
      end
      bus_stop();
   endtask

   initial begin
      logic a;
      logic [7:0] v;
      for (int i = 0; i < NREG; i++) exp_regs[i] = 8'h00;
      tick(5);
      rst_n = 1'b1;
      tick(3);
      // R10: reset state
      check8("R10 regs zero", {7'd0, |regs_o}, 8'd0);
      check8("R10 sda released", {7'd0, sda_oe}, 8'd0);
      cmp_en = 1;

      // R1 R3 R4: strap 10 -> address 1100010, write byte 0xC4
      wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
      wr_txn(8'hC4, 8'h00, 3, "R1");
      check8("R4 reg2", regs_o[2*8 +: 8], 8'h33);

      // R5: run past the last register, then start beyond it
      wbuf[0] = 8'hAA; wbuf[1] = 8'hBB; wbuf[2] = 8'hCC; wbuf[3] = 8'hDD;
      wr_txn(8'hC4, 8'h0A, 4, "R5");
      check8("R5 reg0 no wrap", regs_o[0 +: 8], 8'h11);
      check8("R5 reg11", regs_o[11*8 +: 8], 8'hBB);
      wbuf[0] = 8'h55;
      wr_txn(8'hC4, 8'h0C, 1, "R5");

      // R11: byte after data is data, not a new pointer
      wbuf[0] = 8'h44; wbuf[1] = 8'h05;
      wr_txn(8'hC4, 8'h03, 2, "R11");
      check8("R11 reg4 data", regs_o[4*8 +: 8], 8'h05);
      check8("R11 reg5 untouched", regs_o[5*8 +: 8], 8'h00);

      // R6: wrong strap bits (address 1100000) -> no ack, bus ignored
      bus_start();
      send_byte(8'hC0, -1, a); check8("R6 no ack addr", {7'd0, a}, 8'd0);
      send_byte(8'h00, -1, a); check8("R6 no ack sub", {7'd0, a}, 8'd0);
      send_byte(8'h77, -1, a); check8("R6 no ack data", {7'd0, a}, 8'd0);
      bus_stop();
      check8("R6 reg0 kept", regs_o[0 +: 8], 8'h11);

      // R1: other strap value selects a different address
      strap = 2'b01;
      wbuf[0] = 8'h66;
      wr_txn(8'hC2, 8'h07, 1, "R1");

      // R2: stop inside a data byte stores nothing
      bus_start();
      send_byte(8'hC2, -1, a); check8("R2 addr ack", {7'd0, a}, 8'd1);
      send_byte(8'h06, -1, a); check8("R2 sub ack", {7'd0, a}, 8'd1);
      for (int i = 0; i < 4; i++) clk_bit(1'b1, a);
      bus_stop();
      check8("R2 reg6 kept", regs_o[6*8 +: 8], 8'h00);
      check8("R2 sda released", {7'd0, sda_oe}, 8'd0);

      // R7 R8 R9: read, inputs change after address, master ack then nack
      lock = 1'b1; sb = 3'd5;
      bus_start();
      send_byte(8'hC3, -1, a); check8("R7 read addr ack", {7'd0, a}, 8'd1);
      lock = 1'b0; sb = 3'd2;
      recv_byte(1'b1, v); check8("R7 status byte", v, 8'hA8);
      recv_byte(1'b0, v); check8("R8 held status", v, 8'hA8);
      recv_byte(1'b0, v); check8("R9 silent after nack", v, 8'hFF);
      bus_stop();

      // R7: unlocked with sub-band 7
      lock = 1'b0; sb = 3'd7;
      bus_start();
      send_byte(8'hC3, -1, a); check8("R7 addr ack 2", {7'd0, a}, 8'd1);
      recv_byte(1'b0, v); check8("R7 status unlocked", v, 8'h38);
      bus_stop();

      tick(10);
      if (!done) begin
         done = 1;
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog act=timeout exp=finish");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end
endmodule